// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable behavioural model of a word-organised serial EEPROM with 256 words of 16 bits. A host reaches it over a three-wire link: chip select, serial clock and serial data in, with a single data-out line that the block releases (output enable low) whenever chip select is low. The block runs on a fast system clock. Chip select, serial clock, data in and the two level inputs (write enable, protect enable) pass through synchronizers, and the block acts on the serial-clock rising edges it detects.

Each instruction is a start bit, a 4-bit opcode and an 8-bit address. Write-type instructions add 16-bit data words. The block supports word read with endless sequential streaming, single-word write, page write of up to four words, write of the whole array, and three instructions for a protect limit: load it, read it, and lock it for good. A write-type instruction takes effect when chip select is released. It then starts a self-timed programming cycle. During that cycle the data line reports busy while the host holds chip select high, and it reports ready once the cycle ends. Every store overwrites the old value directly, so no erase is needed first.

When protect enable is high, every address at or above the protect limit is write-protected. A one-time lock bit freezes that limit.

Top module: `eep_microwire_slave`

## Requirements
- R1: After reset, every word reads 0x0000, the protect limit is 0xFF with the lock bit clear, and the output enable is low.
- R2: Zero bits before the first 1 are ignored. That first 1 is the start bit. It is followed by a 4-bit opcode and an 8-bit address, each sent MSB first. The opcodes are: read 1000, write 0100, page write 0101, write-all 0001, load limit 1100, read limit 1101, lock 1110.
- R3: For a read, bit 15 of the addressed word is on the data output after the rising edge that carries the last address bit. Each later rising edge presents the next lower bit.
- R4: While chip select stays high, the rising edge after bit 0 presents bit 15 of the word at the next address. The address wraps from 255 to 0.
- R5: A write stores the first complete 16-bit data word at the address when chip select falls. If fewer than 16 data bits were sent, nothing is stored and no cycle starts.
- R6: A page write stores each complete data word, up to four of them, at consecutive addresses (modulo 256) from the given address. Words after the fourth are ignored.
- R7: Write-all stores the first data word into all 256 words.
- R8: While protect enable is high, a write or page write is rejected entirely, with no store and no cycle, if any target address is greater than or equal to the protect limit. Write-all is rejected whenever protect enable is high.
- R9: Load-limit takes the new limit from the address field. Lock sets the lock bit permanently. After that, load-limit is rejected. Read-limit streams {7'b0, lock, limit}.
- R10: An accepted write-type instruction starts a cycle of PROG_CYCLES system clocks. With chip select high, the output is driven low during the cycle and high once it ends.
- R11: Instructions sent while a cycle is running are ignored.
- R12: The output enable is low while chip select is low.
- R13: Write-type instructions are ignored, with no store and no cycle, unless write enable is high when chip select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select from host |
| sk_i | input | 1 | Serial clock from host |
| di_i | input | 1 | Serial data from host |
| we_i | input | 1 | Write enable level |
| pre_i | input | 1 | Protect enable level |
| dout_o | output | 1 | Serial data / busy-ready status |
| dout_oe_o | output | 1 | Output enable for dout_o (low = high impedance) |

## Verification
The checker watches several rules on every cycle. The output is released a few cycles after chip select goes low. The line never reads ready while a cycle is running. Each programming cycle lasts exactly the parameter length. The lock bit never clears, and once it is set the limit cannot move. Nothing in the protect state changes during a cycle. Data ordering, streaming wrap, page placement, protection rejection, write-enable gating, incomplete frames and ignored instructions during busy can only be shown by the bench: it writes through the serial link and reads back against a model array.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;
    localparam int OP_W     = 4;
    localparam int HDR_BITS = OP_W + ADDR_W;

    typedef enum logic [OP_W-1:0] {
        OP_READ  = 4'b1000,
        OP_WRITE = 4'b0100,
        OP_PAGE  = 4'b0101,
        OP_WRALL = 4'b0001,
        OP_PLOAD = 4'b1100,
        OP_PREAD = 4'b1101,
        OP_PLOCK = 4'b1110
    } op_e;

    typedef enum logic [1:0] {
        M_CMD  = 2'd0,
        M_READ = 2'd1,
        M_POLL = 2'd2
    } mode_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
    } hdr_t;

    // Address falls inside the guarded region
    function automatic logic addr_guarded(input logic pre,
                                          input logic [ADDR_W-1:0] a,
                                          input logic [ADDR_W-1:0] lim);
        return pre && (a >= lim);
    endfunction

    // Word streamed by the limit-read instruction
    function automatic logic [DATA_W-1:0] limit_word(input logic lock,
                                                     input logic [ADDR_W-1:0] lim);
        return {{(DATA_W-ADDR_W-1){1'b0}}, lock, lim};
    endfunction
endpackage

// File: rtl/eep_sync_bank.sv
module eep_sync_bank #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] sh_q;
        always_ff @(posedge clk_i) begin
            if (rst_i) sh_q <= '0;
            else       sh_q <= {sh_q[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = sh_q[STAGES-1];
    end
endmodule

// File: rtl/eep_cmd_shift.sv
module eep_cmd_shift
    import eep_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              clr_i,
    input  logic              bit_stb_i,
    input  logic              bit_i,
    output logic              hdr_done_o,
    output logic              hdr_full_o,
    output hdr_t              hdr_o,
    output logic              word_stb_o,
    output logic [DATA_W-1:0] word_o
);
    localparam int HC_W = $clog2(HDR_BITS);
    localparam int DC_W = $clog2(DATA_W);

    logic                started_q, full_q, hdr_done_q, word_stb_q;
    logic [HC_W-1:0]     hcnt_q;
    logic [HDR_BITS-1:0] hsr_q;
    logic [DC_W-1:0]     dcnt_q;
    logic [DATA_W-1:0]   dsr_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            started_q  <= 1'b0;
            full_q     <= 1'b0;
            hdr_done_q <= 1'b0;
            word_stb_q <= 1'b0;
            hcnt_q     <= '0;
            hsr_q      <= '0;
            dcnt_q     <= '0;
            dsr_q      <= '0;
        end else begin
            hdr_done_q <= 1'b0;
            word_stb_q <= 1'b0;
            if (bit_stb_i) begin
                if (!started_q) begin
                    started_q <= bit_i;
                end else if (!full_q) begin
                    hsr_q  <= {hsr_q[HDR_BITS-2:0], bit_i};
                    hcnt_q <= hcnt_q + 1'b1;
                    if (hcnt_q == HC_W'(HDR_BITS-1)) begin
                        full_q     <= 1'b1;
                        hdr_done_q <= 1'b1;
                    end
                end else begin
                    dsr_q  <= {dsr_q[DATA_W-2:0], bit_i};
                    dcnt_q <= dcnt_q + 1'b1;
                    if (dcnt_q == DC_W'(DATA_W-1)) word_stb_q <= 1'b1;
                end
            end
        end
    end

    assign hdr_done_o = hdr_done_q;
    assign hdr_full_o = full_q;
    assign hdr_o      = hdr_t'(hsr_q);
    assign word_stb_o = word_stb_q;
    assign word_o     = dsr_q;
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
    parameter int CYCLES = 500
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)                       cnt_q <= '0;
        else if (start_i && cnt_q == '0) cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eep_microwire_slave.sv
module eep_microwire_slave
    import eep_pkg::*;
#(
    parameter int PAGE_WORDS  = 4,
    parameter int PROG_CYCLES = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    input  logic we_i,
    input  logic pre_i,
    output logic dout_o,
    output logic dout_oe_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int WC_W  = $clog2(PAGE_WORDS + 1);
    localparam int PI_W  = $clog2(PAGE_WORDS);
    localparam int BC_W  = $clog2(DATA_W);
    localparam int NPIN  = 5;

    // Pin synchronization and edge detection
    logic [NPIN-1:0] pin_s;
    logic cs_s, sk_s, di_s, we_s, pre_s;
    logic cs_prev_q, sk_prev_q;
    logic sk_rise, cs_fall;

    eep_sync_bank #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({pre_i, we_i, di_i, sk_i, cs_i}),
        .q_o   (pin_s)
    );

    assign {pre_s, we_s, di_s, sk_s, cs_s} = pin_s;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cs_prev_q <= 1'b0;
            sk_prev_q <= 1'b0;
        end else begin
            cs_prev_q <= cs_s;
            sk_prev_q <= sk_s;
        end
    end

    assign sk_rise = sk_s && !sk_prev_q;
    assign cs_fall = !cs_s && cs_prev_q;

    // State
    mode_e             mode_q;
    logic              busy;
    logic              commit;
    logic [ADDR_W-1:0] prot_q;
    logic              lock_q;

    // Frame decoding
    logic              hdr_done, hdr_full, word_stb;
    hdr_t              hdr;
    logic [DATA_W-1:0] word;

    eep_cmd_shift u_cmd (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .clr_i      (!cs_s),
        .bit_stb_i  (sk_rise && cs_s && (mode_q == M_CMD)),
        .bit_i      (di_s),
        .hdr_done_o (hdr_done),
        .hdr_full_o (hdr_full),
        .hdr_o      (hdr),
        .word_stb_o (word_stb),
        .word_o     (word)
    );

    eep_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (commit),
        .busy_o  (busy)
    );

    // Page buffer: collects up to PAGE_WORDS data words per frame
    logic [DATA_W-1:0] pbuf_q [PAGE_WORDS];
    logic [WC_W-1:0]   wcnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wcnt_q <= '0;
            for (int i = 0; i < PAGE_WORDS; i++) pbuf_q[i] <= '0;
        end else if (!cs_s) begin
            wcnt_q <= '0;
        end else if (word_stb && (wcnt_q < WC_W'(PAGE_WORDS))) begin
            pbuf_q[wcnt_q[PI_W-1:0]] <= word;
            wcnt_q <= wcnt_q + 1'b1;
        end
    end

    // Acceptance of a write-type frame at chip-select release
    logic frame_ok, guard, page_hit;

    always_comb begin
        page_hit = 1'b0;
        for (int i = 0; i < PAGE_WORDS; i++)
            if (i < int'(wcnt_q))
                page_hit = page_hit | addr_guarded(pre_s, hdr.addr + ADDR_W'(i), prot_q);
        frame_ok = 1'b0;
        guard    = 1'b0;
        case (hdr.op)
            OP_WRITE: begin
                frame_ok = (wcnt_q != '0);
                guard    = addr_guarded(pre_s, hdr.addr, prot_q);
            end
            OP_PAGE: begin
                frame_ok = (wcnt_q != '0);
                guard    = page_hit;
            end
            OP_WRALL: begin
                frame_ok = (wcnt_q != '0);
                guard    = pre_s;
            end
            OP_PLOAD, OP_PLOCK: begin
                frame_ok = 1'b1;
                guard    = lock_q;
            end
            default: ;
        endcase
    end

    assign commit = cs_fall && (mode_q == M_CMD) && hdr_full && we_s
                    && frame_ok && !guard && !busy;

    // Storage array, one register word per address
    logic [DEPTH-1:0][DATA_W-1:0] mem_w;

    for (genvar j = 0; j < DEPTH; j++) begin : g_word
        logic              hit;
        logic [DATA_W-1:0] nxt;
        logic [DATA_W-1:0] word_q;

        always_comb begin
            hit = 1'b0;
            nxt = pbuf_q[0];
            if (commit) begin
                case (hdr.op)
                    OP_WRITE: hit = (hdr.addr == ADDR_W'(j));
                    OP_WRALL: hit = 1'b1;
                    OP_PAGE: begin
                        for (int i = 0; i < PAGE_WORDS; i++) begin
                            if ((i < int'(wcnt_q)) && (hdr.addr + ADDR_W'(i) == ADDR_W'(j))) begin
                                hit = 1'b1;
                                nxt = pbuf_q[i];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk_i) begin
            if (rst_i)    word_q <= '0;
            else if (hit) word_q <= nxt;
        end

        assign mem_w[j] = word_q;
    end

    // Read shifter, protect state and mode sequencing
    logic [DATA_W-1:0] rd_sr_q;
    logic [ADDR_W-1:0] rd_ptr_q;
    logic [BC_W-1:0]   rd_bit_q;
    logic              rd_mem_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q   <= M_CMD;
            rd_sr_q  <= '0;
            rd_ptr_q <= '0;
            rd_bit_q <= '0;
            rd_mem_q <= 1'b0;
            prot_q   <= '1;
            lock_q   <= 1'b0;
        end else begin
            case (mode_q)
                M_CMD: begin
                    if (commit) begin
                        mode_q <= M_POLL;
                        if (hdr.op == OP_PLOAD) prot_q <= hdr.addr;
                        if (hdr.op == OP_PLOCK) lock_q <= 1'b1;
                    end else if (hdr_done && cs_s) begin
                        if (hdr.op == OP_READ) begin
                            rd_sr_q  <= mem_w[hdr.addr];
                            rd_ptr_q <= hdr.addr + 1'b1;
                            rd_bit_q <= '0;
                            rd_mem_q <= 1'b1;
                            mode_q   <= M_READ;
                        end else if (hdr.op == OP_PREAD) begin
                            rd_sr_q  <= limit_word(lock_q, prot_q);
                            rd_bit_q <= '0;
                            rd_mem_q <= 1'b0;
                            mode_q   <= M_READ;
                        end
                    end
                end
                M_READ: begin
                    if (!cs_s) begin
                        mode_q <= M_CMD;
                    end else if (sk_rise) begin
                        if (rd_bit_q == BC_W'(DATA_W-1)) begin
                            rd_bit_q <= '0;
                            if (rd_mem_q) begin
                                rd_sr_q  <= mem_w[rd_ptr_q];
                                rd_ptr_q <= rd_ptr_q + 1'b1;
                            end else begin
                                rd_sr_q  <= limit_word(lock_q, prot_q);
                            end
                        end else begin
                            rd_sr_q  <= {rd_sr_q[DATA_W-2:0], 1'b0};
                            rd_bit_q <= rd_bit_q + 1'b1;
                        end
                    end
                end
                M_POLL: begin
                    if (!busy && !cs_s) mode_q <= M_CMD;
                end
                default: mode_q <= M_CMD;
            endcase
        end
    end

    assign dout_oe_o = cs_s && ((mode_q == M_READ) || (mode_q == M_POLL));
    assign dout_o    = (mode_q == M_READ) ? rd_sr_q[DATA_W-1] : !busy;
endmodule

// File: rtl/eep_microwire_slave_chk.sv
module eep_microwire_slave_chk
    import eep_pkg::*;
#(
    parameter int PROG_CYCLES = 500
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              cs_i,
    input logic              dout_o,
    input logic              dout_oe_o,
    input logic              busy_i,
    input logic              lock_i,
    input logic [ADDR_W-1:0] prot_i
);
    int run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)       run_q <= 0;
        else if (busy_i) run_q <= run_q + 1;
        else             run_q <= 0;
    end

    // R12: line released once chip select has been low for a few cycles
    p_hiz_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cs_i && !$past(cs_i) && !$past(cs_i, 2) && !$past(cs_i, 3)) |-> !dout_oe_o);

    // R10: a driven line never shows ready while a cycle runs
    p_busy_low_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_i && dout_oe_o) |-> !dout_o);

    // R10: each programming cycle lasts exactly PROG_CYCLES clocks
    p_prog_len_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_i) |-> (run_q == PROG_CYCLES));

    // R9: the lock bit never clears
    p_lock_sticky_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        lock_i |=> lock_i);

    // R9: a locked limit never moves
    p_limit_frozen_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        lock_i |=> $stable(prot_i));

    // R11: protect state is untouched while a cycle runs
    p_busy_quiet_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_i |=> ($stable(prot_i) && $stable(lock_i)));
endmodule

bind eep_microwire_slave eep_microwire_slave_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cs_i      (cs_i),
    .dout_o    (dout_o),
    .dout_oe_o (dout_oe_o),
    .busy_i    (busy),
    .lock_i    (lock_q),
    .prot_i    (prot_q)
);

// File: tb/eep_microwire_slave_tb.sv
module eep_microwire_slave_tb_top;
    localparam int PROG = 600;
    localparam int HP   = 8;
    localparam int WDOG = 190000;

    localparam logic [3:0] C_RD  = 4'b1000;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PG  = 4'b0101;
    localparam logic [3:0] C_ALL = 4'b0001;
    localparam logic [3:0] C_PLD = 4'b1100;
    localparam logic [3:0] C_PRD = 4'b1101;
    localparam logic [3:0] C_LCK = 4'b1110;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, we = 1'b1, pre = 1'b0;
    logic dout, dout_oe;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    logic [15:0] model [256];
    logic [15:0] wbuf  [6];
    logic [7:0]  lim_m  = 8'hFF;
    logic        lock_m = 1'b0;
    logic        last_q;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    eep_microwire_slave #(.PAGE_WORDS(4), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) dut_i (
        .clk_i (clk), .rst_i (rst), .cs_i (cs), .sk_i (sk), .di_i (di),
        .we_i (we), .pre_i (pre), .dout_o (dout), .dout_oe_o (dout_oe)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] lim_word();
        return {7'b0, lock_m, lim_m};
    endfunction

    task automatic sk_bit(input logic d, output logic q);
        di = d;
        wait_clk(HP);
        sk = 1'b1;
        wait_clk(HP);
        q  = dout;
        sk = 1'b0;
    endtask

    task automatic send_cmd(input logic [3:0] op, input logic [7:0] addr,
                            input int nbits, input int lead);
        logic q;
        cs = 1'b1;
        wait_clk(HP);
        for (int i = 0; i < lead; i++) sk_bit(1'b0, q);
        sk_bit(1'b1, q);
        for (int i = 3; i >= 0; i--) sk_bit(op[i], q);
        for (int i = 7; i >= 0; i--) sk_bit(addr[i], q);
        for (int b = 0; b < nbits; b++) sk_bit(wbuf[b / 16][15 - (b % 16)], q);
        last_q = q;
    endtask

    task automatic end_cs();
        sk = 1'b0; di = 1'b0; cs = 1'b0;
        wait_clk(3 * HP);
    endtask

    // Read nw words after sending a read-type header, compare to model or limit word
    task automatic do_read(input logic [3:0] op, input logic [7:0] addr,
                           input int nw, input int lead, input string req);
        logic [15:0] got, exp;
        logic q;
        send_cmd(op, addr, 0, lead);
        q = last_q;
        for (int w = 0; w < nw; w++) begin
            got[15] = q;
            for (int k = 14; k >= 0; k--) begin
                sk_bit(1'b0, q);
                got[k] = q;
            end
            exp = (op == C_PRD) ? lim_word() : model[8'(int'(addr) + w)];
            check(got == exp, req, "read word", 32'(got), 32'(exp));
            if (w != nw - 1) sk_bit(1'b0, q);
        end
        end_cs();
    endtask

    // Frame expected to start a cycle: check busy then ready timing
    task automatic write_poll(input logic [3:0] op, input logic [7:0] addr,
                              input int nbits, input int lead, input string req);
        int t0, el;
        send_cmd(op, addr, nbits, lead);
        sk = 1'b0; di = 1'b0; cs = 1'b0;
        t0 = cyc;
        wait_clk(2 * HP);
        cs = 1'b1;
        wait_clk(6);
        check(dout_oe && !dout, "R10", "busy shown", {dout_oe, dout}, 32'h2);
        while (!dout && (cyc - t0) < PROG + 100) wait_clk(1);
        el = cyc - t0;
        check((el >= PROG) && (el <= PROG + 20), req, "ready after cycle", el, PROG);
        end_cs();
    endtask

    // Frame expected to be rejected: no cycle, so the line stays released
    task automatic write_reject(input logic [3:0] op, input logic [7:0] addr,
                                input int nbits, input string req);
        send_cmd(op, addr, nbits, 0);
        sk = 1'b0; di = 1'b0; cs = 1'b0;
        wait_clk(2 * HP);
        cs = 1'b1;
        wait_clk(6);
        check(!dout_oe, req, "no cycle started", dout_oe, 0);
        end_cs();
    endtask

    task automatic model_page(input logic [7:0] addr, input int n);
        for (int i = 0; i < n && i < 4; i++) model[8'(int'(addr) + i)] = wbuf[i];
    endtask

    initial begin
        int r, n, kind;
        logic [7:0] a, last_a;
        for (int i = 0; i < 256; i++) model[i] = 16'h0000;
        r = $urandom(32'h5EED);
        wait_clk(10);
        rst = 1'b0;
        wait_clk(5);

        // R1 / R12 reset state
        check(!dout_oe, "R1", "oe after reset", dout_oe, 0);
        do_read(C_PRD, 8'h00, 1, 0, "R1");
        do_read(C_RD, 8'h37, 1, 0, "R1");

        // R7 write-all, then R4 stream with wrap across the full array
        wbuf[0] = 16'hA5C3;
        write_poll(C_ALL, 8'h00, 16, 0, "R7");
        for (int i = 0; i < 256; i++) model[i] = 16'hA5C3;
        do_read(C_RD, 8'h00, 257, 0, "R4");

        // Constrained random mix: R2 leading zeros, R3 reads, R5 writes, R6 pages
        last_a = 8'h00;
        for (int t = 0; t < 16; t++) begin
            kind = int'($urandom % 3);
            a = 8'($urandom);
            for (int i = 0; i < 6; i++) wbuf[i] = 16'($urandom);
            if (kind == 0) begin
                write_poll(C_WR, a, 16, int'($urandom % 3), "R5");
                model[a] = wbuf[0];
                last_a = a;
            end else if (kind == 1) begin
                n = 1 + int'($urandom % 5);
                write_poll(C_PG, a, 16 * n, int'($urandom % 3), "R6");
                model_page(a, n);
                last_a = a;
            end else begin
                do_read(C_RD, a, 1 + int'($urandom % 3), int'($urandom % 3), "R3");
            end
        end
        do_read(C_RD, last_a, 4, 2, "R2");

        // R6 page wraps across 255 -> 0, read back with R4 wrap
        wbuf[0] = 16'h1111; wbuf[1] = 16'h2222; wbuf[2] = 16'h3333;
        write_poll(C_PG, 8'hFE, 48, 0, "R6");
        model_page(8'hFE, 3);
        do_read(C_RD, 8'hFD, 5, 0, "R4");

        // R6 five words: fifth ignored
        for (int i = 0; i < 5; i++) wbuf[i] = 16'hC000 + 16'(i);
        write_poll(C_PG, 8'h60, 80, 0, "R6");
        model_page(8'h60, 5);
        do_read(C_RD, 8'h60, 5, 0, "R6");

        // R5 incomplete frame
        wbuf[0] = 16'hDEAD;
        write_reject(C_WR, 8'h22, 10, "R5");
        do_read(C_RD, 8'h22, 1, 0, "R5");

        // R13 write enable low
        we = 1'b0;
        wbuf[0] = 16'hBEEF;
        write_reject(C_WR, 8'h23, 16, "R13");
        we = 1'b1;
        do_read(C_RD, 8'h23, 1, 0, "R13");

        // R11 instruction during busy is ignored
        wbuf[0] = 16'h4040;
        send_cmd(C_WR, 8'h40, 16, 0);
        model[8'h40] = 16'h4040;
        sk = 1'b0; di = 1'b0; cs = 1'b0;
        wait_clk(2 * HP);
        wbuf[0] = 16'h4141;
        send_cmd(C_WR, 8'h41, 16, 0);
        sk = 1'b0; di = 1'b0; cs = 1'b0;
        wait_clk(2 * HP);
        cs = 1'b1;
        while (!dout) wait_clk(1);
        end_cs();
        do_read(C_RD, 8'h40, 2, 0, "R11");

        // R8 / R9 protection
        write_poll(C_PLD, 8'h80, 0, 0, "R9");
        lim_m = 8'h80;
        do_read(C_PRD, 8'h00, 2, 0, "R9");
        pre = 1'b1;
        wbuf[0] = 16'h9090;
        write_reject(C_WR, 8'h90, 16, "R8");
        wbuf[0] = 16'h1010;
        write_poll(C_WR, 8'h10, 16, 0, "R8");
        model[8'h10] = 16'h1010;
        wbuf[0] = 16'h7E7E; wbuf[1] = 16'h7F7F; wbuf[2] = 16'h8080;
        write_reject(C_PG, 8'h7E, 48, "R8");
        wbuf[0] = 16'h0F0F;
        write_reject(C_ALL, 8'h00, 16, "R8");
        do_read(C_RD, 8'h7E, 3, 0, "R8");
        do_read(C_RD, 8'h10, 1, 0, "R8");
        do_read(C_RD, 8'h90, 1, 0, "R8");
        pre = 1'b0;
        wbuf[0] = 16'h9191;
        write_poll(C_WR, 8'h90, 16, 0, "R8");
        model[8'h90] = 16'h9191;
        do_read(C_RD, 8'h90, 1, 0, "R8");

        // R9 lock, then load rejected
        write_poll(C_LCK, 8'h00, 0, 0, "R9");
        lock_m = 1'b1;
        write_reject(C_PLD, 8'h20, 0, "R9");
        do_read(C_PRD, 8'h00, 1, 0, "R9");
        pre = 1'b1;
        wbuf[0] = 16'h8585;
        write_reject(C_WR, 8'h85, 16, "R8");
        pre = 1'b0;
        do_read(C_RD, 8'h85, 1, 0, "R8");

        // R12 released with chip select low
        wait_clk(10);
        check(!dout_oe, "R12", "oe with cs low", dout_oe, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL all watchdog: actual %0d expected done", WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule